// File: doc/BRIEF.md
# Scan Load-Capture-Unload Sequencer

This block runs the scan test protocol on one scan chain whose total length is fixed when the block is built. After a start request it raises test mode, so that every register of the chain acts as one long shift register. It then moves one stimulus vector in, a single bit per clock, until every bit of the chain is filled. Next it drops test mode for exactly one functional clock, so the chain registers capture the outputs of the logic between them. Finally it raises test mode again and shifts the captured response out.

When several patterns are requested, the unload of one response and the load of the next stimulus happen in the same clocks. Each shift moves one response bit out of the chain and one new stimulus bit into it. After the final capture, a drain phase shifts out the last response without taking any new stimulus. A one-cycle done pulse marks the end of the run.

Stimulus arrives on a valid/ready serial stream. A bit is taken only in a cycle where both `stim_valid` and `stim_ready` are high. If a shift phase needs a bit and `stim_valid` is low, the chain stalls: the chain clock enable stays low, nothing moves and no response bit is produced. The response stream has only a valid flag and cannot be back-pressured. Its consumer must take every bit in the cycle where `resp_valid` is high. Control pins are plain levels or pulses.

Top module: `scan_sequencer`

## Requirements
- R1: In reset and while idle, `scan_mode`, `scan_en`, `stim_ready`, `resp_valid`, `done` and `busy` are all low.
- R2: A start with a nonzero pattern count raises `scan_mode`. Exactly CHAIN_LEN stimulus bits are then accepted before each capture. In each accepted cycle `scan_in` equals `stim_data` and `scan_en` is high.
- R3: While `stim_ready` is high and `stim_valid` is low, `scan_en` and `resp_valid` stay low and the chain does not move.
- R4: Each capture is exactly one cycle with `scan_mode` low and `scan_en` high. In that cycle `stim_ready` and `resp_valid` are low. The cycle after a capture has `scan_mode` high. A run of P patterns has exactly P captures.
- R5: Between two captures, every accepted stimulus bit comes with one response bit in the same cycle: `resp_valid` equals `stim_valid` while `stim_ready` is high.
- R6: Each pattern yields exactly CHAIN_LEN response bits. `resp_data` carries `scan_out` as it was before each shift edge, so the chain element farthest from `scan_in` leaves first.
- R7: `resp_valid` stays low from the start of a run until its first capture.
- R8: After the last capture, the block shifts CHAIN_LEN consecutive cycles with `resp_valid` and `scan_en` high and `stim_ready` low. It does not wait for `stim_valid` during this phase.
- R9: `done` is a one-cycle pulse in the cycle after the last response bit. In the following cycle the block is idle again with `busy` low.
- R10: A start with a pattern count of zero gives a `done` pulse in the next cycle and never raises `scan_mode` or `scan_en`.
- R11: `start` is ignored while `busy` is high. A run in progress keeps the pattern count it latched at its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run; sampled only while idle |
| num_patterns | input | PAT_W | Number of patterns for the run, latched at start |
| stim_valid | input | 1 | Stimulus bit available |
| stim_data | input | 1 | Stimulus bit |
| stim_ready | output | 1 | Sequencer can take a stimulus bit this cycle |
| resp_valid | output | 1 | Response bit valid this cycle |
| resp_data | output | 1 | Response bit |
| scan_mode | output | 1 | Test mode to all chain registers (high = shift) |
| scan_en | output | 1 | Clock enable of the chain registers |
| scan_in | output | 1 | Serial input of the chain |
| scan_out | input | 1 | Serial output of the chain |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
The bench stalls the stimulus stream in a fixed pattern in the middle of shift phases. A design that let the chain clock run during a stall would fill the chain with stale bits, and the captured responses would come back wrong. It checks that a capture lasts exactly one cycle with test mode low. A design that held test mode low for two clocks, or that let the capture cycle take a stimulus bit, would fail the capture count and the response comparison. The bench also covers runs of one pattern and of several patterns, to catch an off-by-one in the pattern count: such a design would skip the drain or drain too early, which shows up as the wrong number of response bits. The last cases are a zero-pattern start, which must not touch the chain, and a second start during a run, which must not change the latched count.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE    = 3'd0,
    SQ_LOAD    = 3'd1,
    SQ_CAPTURE = 3'd2,
    SQ_XCHG    = 3'd3,
    SQ_DRAIN   = 3'd4,
    SQ_DONE    = 3'd5
  } seq_state_e;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/scan_shift_counter.sv
module scan_shift_counter #(
  parameter int unsigned CHAIN_LEN = 16,
  parameter int unsigned CW        = scan_seq_pkg::cnt_width(CHAIN_LEN)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reload,
  input  logic step,
  output logic at_zero
);

  localparam logic [CW-1:0] LAST_IDX = CW'(CHAIN_LEN - 1);

  logic [CW-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else if (reload) begin
      remain_q <= LAST_IDX;
    end else if (step && (remain_q != '0)) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign at_zero = (remain_q == '0);

endmodule

// File: rtl/scan_pattern_counter.sv
module scan_pattern_counter #(
  parameter int unsigned PAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PAT_W-1:0] load_val,
  input  logic             consume,
  output logic             on_last
);

  logic [PAT_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (load) begin
      left_q <= load_val;
    end else if (consume && (left_q != '0)) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign on_last = (left_q == PAT_W'(1));

endmodule

// File: rtl/scan_seq_fsm.sv
module scan_seq_fsm
  import scan_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic zero_req,
  input  logic stim_valid,
  input  logic shift_zero,
  input  logic pat_last,
  output logic mode_o,
  output logic ready_o,
  output logic shift_o,
  output logic chain_en_o,
  output logic resp_vld_o,
  output logic cnt_reload_o,
  output logic pat_load_o,
  output logic pat_dec_o,
  output logic busy_o,
  output logic done_o
);

  seq_state_e state_q, state_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      SQ_IDLE:    if (start) state_d = zero_req ? SQ_DONE : SQ_LOAD;
      SQ_LOAD:    if (stim_valid && shift_zero) state_d = SQ_CAPTURE;
      SQ_CAPTURE: state_d = pat_last ? SQ_DRAIN : SQ_XCHG;
      SQ_XCHG:    if (stim_valid && shift_zero) state_d = SQ_CAPTURE;
      SQ_DRAIN:   if (shift_zero) state_d = SQ_DONE;
      SQ_DONE:    state_d = SQ_IDLE;
      default:    state_d = SQ_IDLE;
    endcase
  end

  logic in_take;
  logic in_drain;
  logic in_cap;
  logic idle_go;

  assign in_take  = (state_q == SQ_LOAD) || (state_q == SQ_XCHG);
  assign in_drain = (state_q == SQ_DRAIN);
  assign in_cap   = (state_q == SQ_CAPTURE);
  assign idle_go  = (state_q == SQ_IDLE) && start;

  assign mode_o       = in_take || in_drain;
  assign ready_o      = in_take;
  assign shift_o      = (in_take && stim_valid) || in_drain;
  assign chain_en_o   = shift_o || in_cap;
  assign resp_vld_o   = ((state_q == SQ_XCHG) && stim_valid) || in_drain;
  assign cnt_reload_o = (idle_go && !zero_req) || in_cap;
  assign pat_load_o   = idle_go;
  assign pat_dec_o    = in_cap;
  assign busy_o       = (state_q != SQ_IDLE);
  assign done_o       = (state_q == SQ_DONE);

endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer #(
  parameter int unsigned CHAIN_LEN = 16,
  parameter int unsigned PAT_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [PAT_W-1:0] num_patterns,
  input  logic             stim_valid,
  input  logic             stim_data,
  output logic             stim_ready,
  output logic             resp_valid,
  output logic             resp_data,
  output logic             scan_mode,
  output logic             scan_en,
  output logic             scan_in,
  input  logic             scan_out,
  output logic             busy,
  output logic             done
);

  logic shift_zero;
  logic pat_last;
  logic shift_go;
  logic cnt_reload;
  logic pat_load;
  logic pat_dec;
  logic zero_req;

  assign zero_req = (num_patterns == '0);

  scan_seq_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .zero_req     (zero_req),
    .stim_valid   (stim_valid),
    .shift_zero   (shift_zero),
    .pat_last     (pat_last),
    .mode_o       (scan_mode),
    .ready_o      (stim_ready),
    .shift_o      (shift_go),
    .chain_en_o   (scan_en),
    .resp_vld_o   (resp_valid),
    .cnt_reload_o (cnt_reload),
    .pat_load_o   (pat_load),
    .pat_dec_o    (pat_dec),
    .busy_o       (busy),
    .done_o       (done)
  );

  scan_shift_counter #(.CHAIN_LEN(CHAIN_LEN)) u_shift_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .reload  (cnt_reload),
    .step    (shift_go),
    .at_zero (shift_zero)
  );

  scan_pattern_counter #(.PAT_W(PAT_W)) u_pat_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (pat_load),
    .load_val (num_patterns),
    .consume  (pat_dec),
    .on_last  (pat_last)
  );

  assign scan_in   = stim_ready ? stim_data : 1'b0;
  assign resp_data = resp_valid ? scan_out : 1'b0;

endmodule

// File: rtl/scan_sequencer_checker.sv
module scan_sequencer_checker #(
  parameter int unsigned PAT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [PAT_W-1:0] num_patterns,
  input logic             stim_valid,
  input logic             stim_ready,
  input logic             resp_valid,
  input logic             scan_mode,
  input logic             scan_en,
  input logic             busy,
  input logic             done
);

  logic first_load_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) first_load_q <= 1'b0;
    else if (start && !busy && (num_patterns != '0)) first_load_q <= 1'b1;
    else if (!scan_mode && scan_en) first_load_q <= 1'b0;
  end

  // R1: idle outputs quiet
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(scan_mode || scan_en || stim_ready || resp_valid || done));

  // R2: stimulus is taken only in test mode
  p_ready_in_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stim_ready |-> scan_mode);

  // R3: stall freezes the chain
  p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stim_ready && !stim_valid) |-> (!scan_en && !resp_valid));

  // R4: a capture lasts one cycle
  p_capture_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_mode && scan_en) |=> scan_mode);

  // R4: capture takes no stream traffic
  p_capture_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_mode && scan_en) |-> (!stim_ready && !resp_valid));

  // R5: every response bit is a real shift
  p_resp_is_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (scan_en && scan_mode));

  // R7: no response before the first capture
  p_no_resp_first_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    first_load_q |-> !resp_valid);

  // R9: done is a single pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind scan_sequencer scan_sequencer_checker #(.PAT_W(PAT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .num_patterns (num_patterns),
  .stim_valid   (stim_valid),
  .stim_ready   (stim_ready),
  .resp_valid   (resp_valid),
  .scan_mode    (scan_mode),
  .scan_en      (scan_en),
  .busy         (busy),
  .done         (done)
);

// File: tb/scan_sequencer_test.sv
module scan_sequencer_test;

  localparam int N  = 16;
  localparam int PW = 8;
  localparam int MAXP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [PW-1:0] num_patterns = '0;
  logic stim_valid = 1'b0;
  logic stim_data = 1'b0;
  logic stim_ready, resp_valid, resp_data, scan_mode, scan_en, scan_in, scan_out, busy, done;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  scan_sequencer #(.CHAIN_LEN(N), .PAT_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .num_patterns(num_patterns),
    .stim_valid(stim_valid), .stim_data(stim_data), .stim_ready(stim_ready),
    .resp_valid(resp_valid), .resp_data(resp_data), .scan_mode(scan_mode),
    .scan_en(scan_en), .scan_in(scan_in), .scan_out(scan_out),
    .busy(busy), .done(done)
  );

  // chain under test: shift toward the high end, capture = inverted rotate
  logic [N-1:0] chain = '0;
  always @(posedge clk) begin
    if (scan_en) begin
      if (scan_mode) chain <= {chain[N-2:0], scan_in};
      else           chain <= ~{chain[0], chain[N-1:1]};
    end
  end
  assign scan_out = chain[N-1];

  function automatic logic [N-1:0] stim_vec(input int p, input int seed);
    return N'(32'hA5C3_96E1 ^ (p * 32'h1F35) ^ (seed * 32'h0C07));
  endfunction

  function automatic logic [N-1:0] cap_of(input logic [N-1:0] v);
    return ~{v[0], v[N-1:1]};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // One run. stall: gaps in stim_valid. restart_at: cycle for a stray start (<0: none)
  task automatic run_patterns(input int npat, input bit stall, input int seed,
                              input int restart_at);
    logic [N-1:0] got [MAXP];
    int sp = 0, sk = 0, rp = 0, rk = 0;
    int caps = 0, taken_since_cap = 0, bad_load_len = 0;
    int stall_err = 0, xchg_err = 0, cap_err = 0, first_resp = 0, drain_err = 0;
    int drain_cnt = 0, done_cnt = 0, cyc = 0, scanin_err = 0;
    bit prev_cap = 1'b0, finished = 1'b0;
    for (int i = 0; i < MAXP; i++) got[i] = '0;
    @(negedge clk);
    num_patterns = PW'(npat);
    start = 1'b1;
    stim_valid = 1'b0;
    @(negedge clk);
    start = 1'b0;
    num_patterns = PW'(npat + 2);
    while (!finished && cyc < 4000) begin
      if (cyc == restart_at) start = 1'b1;
      else start = 1'b0;
      stim_valid = !(stall && (cyc % 5 == 2));
      stim_data = (sp < npat) ? stim_vec(sp, seed)[N-1-sk] : 1'b0;
      #1;
      if (prev_cap && !scan_mode) cap_err++;
      prev_cap = !scan_mode && scan_en;
      if (!scan_mode && scan_en) begin
        caps++;
        if (taken_since_cap != N) bad_load_len++;
        taken_since_cap = 0;
        if (stim_ready || resp_valid) cap_err++;
      end
      if (stim_ready) begin
        if (scan_en !== stim_valid) stall_err++;
        if (caps > 0 && resp_valid !== stim_valid) xchg_err++;
        if (caps == 0 && resp_valid) first_resp++;
        if (stim_valid) begin
          if (scan_in !== stim_data) scanin_err++;
          taken_since_cap++;
          sk++;
          if (sk == N) begin sk = 0; sp++; end
        end
      end
      if (caps == npat && caps > 0 && busy && !done && scan_mode) begin
        drain_cnt++;
        if (stim_ready || !resp_valid || !scan_en) drain_err++;
      end
      if (resp_valid) begin
        if (rp < MAXP) got[rp][N-1-rk] = resp_data;
        rk++;
        if (rk == N) begin rk = 0; rp++; end
      end
      if (done) begin
        done_cnt++;
        finished = 1'b1;
      end
      cyc++;
      if (!finished) @(negedge clk);
    end
    stim_valid = 1'b0;
    check("R9 done seen", 32'(done_cnt), 32'd1);
    check("R2 bits per load", 32'(bad_load_len), 32'd0);
    check("R2 scan_in follows stim_data", 32'(scanin_err), 32'd0);
    check("R3 stall holds chain", 32'(stall_err), 32'd0);
    check("R4 capture count", 32'(caps), 32'(npat));
    check("R4 capture single cycle", 32'(cap_err), 32'd0);
    check("R5 overlap resp with stim", 32'(xchg_err), 32'd0);
    check("R7 no resp in first load", 32'(first_resp), 32'd0);
    check("R8 drain length", 32'(drain_cnt), 32'(N));
    check("R8 drain shape", 32'(drain_err), 32'd0);
    check("R6 response count", 32'(rp * N + rk), 32'(npat * N));
    for (int p = 0; p < npat && p < MAXP; p++)
      check("R6 response bits", 32'(got[p]), 32'(cap_of(stim_vec(p, seed))));
    @(negedge clk);
    #1;
    check("R9 done one cycle", 32'(done), 32'd0);
    check("R9 idle after done", 32'(busy), 32'd0);
  endtask

  task automatic t_reset;
    #1;
    check("R1 reset quiet", 32'({scan_mode, scan_en, stim_ready, resp_valid, done, busy}), 32'd0);
  endtask

  task automatic t_zero;
    int mode_seen = 0;
    @(negedge clk);
    num_patterns = '0;
    start = 1'b1;
    #1;
    @(negedge clk);
    start = 1'b0;
    #1;
    check("R10 done next cycle", 32'(done), 32'd1);
    for (int i = 0; i < 4; i++) begin
      if (scan_mode || scan_en) mode_seen++;
      @(negedge clk);
      #1;
    end
    check("R10 chain untouched", 32'(mode_seen), 32'd0);
    check("R1 idle quiet", 32'({scan_mode, scan_en, stim_ready, resp_valid, done, busy}), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    run_patterns(1, 1'b0, 1, -1);
    run_patterns(3, 1'b1, 2, -1);
    run_patterns(2, 1'b0, 3, 20);   // R11: stray start mid-run
    t_zero();
    run_patterns(4, 1'b1, 4, 45);   // R11 again, with stalls
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule